// File: doc/BRIEF.md
# Pixel Cluster Readout Map and Energy-Sum Trigger

This block sits between the per-pixel discriminators of a hexagonally tiled detector and its readout controller. Each discriminator reports a hit as a pixel number and a 2-bit threshold code. The block looks up a readout mask for that pixel and code in a writable table. After reset, each table entry selects the hit pixel and its six hex neighbours. A hit opens a gather window of programmable length. Masks from every hit that lands in the window are ORed together. When the window closes, the block emits a single-cycle readout pulse carrying the merged mask.

In sum mode, pixels report 8-bit energies on a separate port while the window is open. Energies from pixels inside the window's mask are added into a saturating total. When the window closes, the total is compared against a programmable threshold. Suppose a cluster spreads over n pixels and each pixel's discriminator is set to a 1/n share of the wanted cluster energy. Every pixel of such a cluster then gets the chance to report, so a low-energy event spread over several pixels still fires the trigger.

Pixels are numbered in a rhombus of axial hex coordinates: pixel p has column q = p mod COLS and row r = p / COLS. Its neighbours are (q±1, r), (q, r±1), (q+1, r−1) and (q−1, r+1). A neighbour is kept only if it exists and its index is below NUM_PIX.

Top module: `cluster_sum_trigger`

## Requirements
- R1: After reset, ro_valid, clus_trig and ro_mask are 0. For codes 01, 10 and 11, every table entry of pixel p holds p plus its in-range axial neighbours.
- R2: A hit with code 00 is not a hit and opens no window. A hit naming a pixel at or above NUM_PIX is also not a hit and opens no window.
- R3: A hit at clock edge t, while no window is open, opens a window with W = cfg_window (a value of 0 counts as 1). ro_valid rises for exactly one cycle after edge t+W.
- R4: The ro_mask issued with ro_valid is the OR of the table masks of all hits on edges t through t+W, including the closing edge. ro_mask is 0 whenever ro_valid is 0.
- R5: The table entry at address pixel*4+code is replaced by tbl_data on an edge with tbl_we high. The new entry is used by hits from the next edge onward.
- R6: An energy report (nrg_valid, nrg_pix, nrg_val) on edges t through t+W is added to the window total only if nrg_pix is in the mask merged so far, including any hit on the same edge. Other reports are ignored.
- R7: clus_trig pulses together with ro_valid exactly when cfg_sum_en is high and the window total is at least cfg_sum_thr. It never pulses without ro_valid.
- R8: The window total saturates at 2^SUM_W−1 (2047 by default) instead of wrapping.
- R9: Hits on the same pixel with different threshold codes select different table entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_pix | input | PIX_W | Pixel number of the broadcast hit |
| hit_code | input | 2 | Threshold code: 00 none, 01 low, 10 mid, 11 high |
| nrg_valid | input | 1 | Energy report present |
| nrg_pix | input | PIX_W | Pixel giving the energy report |
| nrg_val | input | 8 | Reported energy |
| cfg_sum_en | input | 1 | Enables the energy-sum trigger |
| cfg_sum_thr | input | SUM_W | Cluster energy threshold |
| cfg_window | input | WIN_W | Gather window length in cycles |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | PIX_W+2 | Table address, pixel*4+code |
| tbl_data | input | NUM_PIX | Readout mask to store |
| ro_valid | output | 1 | One-cycle readout pulse at window close |
| ro_mask | output | NUM_PIX | Pixels to read out |
| clus_trig | output | 1 | Cluster energy-sum trigger pulse |

## Verification
The main function is exercised with several hit patterns. A lone hit at an interior pixel, a corner pixel and the last pixel separates correct neighbour clipping from wraparound across rows. Two hits inside one window, one of them on the closing edge, show whether masks merge or a second window starts. Window lengths 0, 1 and 5 pin down the close timing. Energy patterns mix reports inside and outside the cluster and use totals exactly at and one below the threshold. A long run of full-scale energies separates saturation from wraparound.

// File: rtl/cst_pkg.sv
package cst_pkg;
   localparam int CODE_W   = 2;
   localparam int ENERGY_W = 8;

   typedef enum logic [CODE_W-1:0] {
      THR_NONE = 2'b00,
      THR_LOW  = 2'b01,
      THR_MID  = 2'b10,
      THR_HIGH = 2'b11
   } thr_code_e;
endpackage

// File: rtl/cst_map_table.sv
module cst_map_table #(
   parameter int NUM_PIX = 127,
   parameter int COLS    = 16,
   parameter int PIX_W   = 7,
   localparam int ADDR_W = PIX_W + cst_pkg::CODE_W,
   localparam int DEPTH  = NUM_PIX * (1 << cst_pkg::CODE_W)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [NUM_PIX-1:0] wr_data,
   input  logic [PIX_W-1:0]   rd_pix,
   input  logic [1:0]         rd_code,
   output logic [NUM_PIX-1:0] rd_mask
);
   logic [NUM_PIX-1:0] mem [DEPTH];

   function automatic logic [NUM_PIX-1:0] home_mask(input int p);
      logic [NUM_PIX-1:0] m;
      int q, r, nq, nr, dq, dr;
      m = '0;
      q = p % COLS;
      r = p / COLS;
      m[p] = 1'b1;
      for (int k = 0; k < 6; k++) begin
         dq = (k == 0 || k == 4) ? 1 : (k == 1 || k == 5) ? -1 : 0;
         dr = (k == 2 || k == 5) ? 1 : (k == 3 || k == 4) ? -1 : 0;
         nq = q + dq;
         nr = r + dr;
         if (nq >= 0 && nq < COLS && nr >= 0 && (nr * COLS + nq) < NUM_PIX)
            m[nr * COLS + nq] = 1'b1;
      end
      return m;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= (i % 4 == 0) ? '0 : home_mask(i / 4);
      end else if (wr_en && int'(wr_addr) < DEPTH) begin
         mem[wr_addr] <= wr_data;
      end
   end

   always_comb begin
      rd_mask = '0;
      if (int'(rd_pix) < NUM_PIX)
         rd_mask = mem[{rd_pix, rd_code}];
   end

   // R5: a write is visible in the next cycle
   p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_addr) < DEPTH) |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/cst_gather.sv
module cst_gather #(
   parameter int NUM_PIX = 127,
   parameter int PIX_W   = 7,
   parameter int WIN_W   = 8
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit_ok,
   input  logic [NUM_PIX-1:0] hit_mask,
   input  logic               nrg_ok,
   input  logic [PIX_W-1:0]   nrg_pix,
   input  logic [WIN_W-1:0]   cfg_window,
   output logic               start,
   output logic               upd,
   output logic               closing,
   output logic               nrg_member,
   output logic [NUM_PIX-1:0] merged
);
   logic               open_q;
   logic [WIN_W-1:0]   cnt_q;
   logic [NUM_PIX-1:0] mask_q;
   logic [WIN_W-1:0]   win_eff;

   assign win_eff    = (cfg_window == '0) ? WIN_W'(1) : cfg_window;
   assign start      = hit_ok && !open_q;
   assign upd        = start || open_q;
   assign closing    = open_q && (cnt_q == WIN_W'(1));
   assign merged     = (open_q ? mask_q : '0) | (hit_ok ? hit_mask : '0);
   assign nrg_member = nrg_ok && merged[nrg_pix];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
         mask_q <= '0;
      end else if (start) begin
         open_q <= 1'b1;
         cnt_q  <= win_eff;
         mask_q <= hit_mask;
      end else if (open_q) begin
         mask_q <= merged;
         if (closing) open_q <= 1'b0;
         else         cnt_q  <= cnt_q - WIN_W'(1);
      end
   end

   // R3: an open window always has cycles left to count
   p_cnt_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
      open_q |-> (cnt_q != '0));
   // R4: the merged mask only grows while the window stays open
   p_mask_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && !closing) |=> ((mask_q & $past(mask_q)) == $past(mask_q)));
endmodule

// File: rtl/cst_energy_acc.sv
module cst_energy_acc #(
   parameter int E_W      = 8,
   parameter int SUM_W    = 11,
   parameter bit SATURATE = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             upd,
   input  logic             add_en,
   input  logic [E_W-1:0]   add_val,
   output logic [SUM_W-1:0] sum_nxt
);
   logic [SUM_W-1:0] sum_q;
   logic [SUM_W:0]   wide;

   assign wide = {1'b0, (clear ? '0 : sum_q)} + (SUM_W+1)'(add_en ? add_val : '0);

   generate
      if (SATURATE) begin : g_sat
         assign sum_nxt = wide[SUM_W] ? '1 : wide[SUM_W-1:0];
      end else begin : g_wrap
         assign sum_nxt = wide[SUM_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   sum_q <= '0;
      else if (upd) sum_q <= sum_nxt;
   end

   generate
      if (SATURATE) begin : g_chk
         // R8: the running total never drops inside a window
         p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (upd && !clear) |=> (sum_q >= $past(sum_q)));
      end
   endgenerate
endmodule

// File: rtl/cluster_sum_trigger.sv
module cluster_sum_trigger
   import cst_pkg::*;
#(
   parameter int  NUM_PIX     = 127,
   parameter int  COLS        = 16,
   parameter int  WIN_W       = 8,
   parameter int  MAX_CONTRIB = 7,
   parameter bit  SATURATE    = 1'b1,
   localparam int PIX_W  = $clog2(NUM_PIX),
   localparam int SUM_W  = ENERGY_W + $clog2(MAX_CONTRIB + 1),
   localparam int ADDR_W = PIX_W + CODE_W
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PIX_W-1:0]    hit_pix,
   input  logic [CODE_W-1:0]   hit_code,
   input  logic                nrg_valid,
   input  logic [PIX_W-1:0]    nrg_pix,
   input  logic [ENERGY_W-1:0] nrg_val,
   input  logic                cfg_sum_en,
   input  logic [SUM_W-1:0]    cfg_sum_thr,
   input  logic [WIN_W-1:0]    cfg_window,
   input  logic                tbl_we,
   input  logic [ADDR_W-1:0]   tbl_addr,
   input  logic [NUM_PIX-1:0]  tbl_data,
   output logic                ro_valid,
   output logic [NUM_PIX-1:0]  ro_mask,
   output logic                clus_trig
);
   if (NUM_PIX < 2)                  begin : g_bad_pix   $error("NUM_PIX too small");   end
   if (COLS < 1 || COLS > NUM_PIX)   begin : g_bad_cols  $error("COLS out of range");   end
   if (WIN_W < 1)                    begin : g_bad_win   $error("WIN_W must be >= 1");  end
   if (MAX_CONTRIB < 1)              begin : g_bad_contr $error("MAX_CONTRIB < 1");     end

   logic               hit_ok, nrg_ok;
   logic [NUM_PIX-1:0] hit_mask, merged;
   logic               start, upd, closing, nrg_member;
   logic [SUM_W-1:0]   sum_nxt;

   assign hit_ok = (hit_code != THR_NONE) && (int'(hit_pix) < NUM_PIX);
   assign nrg_ok = nrg_valid && (int'(nrg_pix) < NUM_PIX);

   cst_map_table #(.NUM_PIX(NUM_PIX), .COLS(COLS), .PIX_W(PIX_W)) u_table (
      .clk, .rst_n,
      .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_data(tbl_data),
      .rd_pix(hit_pix), .rd_code(hit_code), .rd_mask(hit_mask));

   cst_gather #(.NUM_PIX(NUM_PIX), .PIX_W(PIX_W), .WIN_W(WIN_W)) u_gather (
      .clk, .rst_n,
      .hit_ok, .hit_mask, .nrg_ok, .nrg_pix, .cfg_window,
      .start, .upd, .closing, .nrg_member, .merged);

   cst_energy_acc #(.E_W(ENERGY_W), .SUM_W(SUM_W), .SATURATE(SATURATE)) u_acc (
      .clk, .rst_n,
      .clear(start), .upd, .add_en(nrg_member), .add_val(nrg_val), .sum_nxt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ro_valid  <= 1'b0;
         ro_mask   <= '0;
         clus_trig <= 1'b0;
      end else begin
         ro_valid  <= closing;
         ro_mask   <= closing ? merged : '0;
         clus_trig <= closing && cfg_sum_en && (sum_nxt >= cfg_sum_thr);
      end
   end

   // R7: the trigger only ever comes with a readout pulse
   p_trig_framed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clus_trig |-> ro_valid);
   // R7: no trigger unless sum mode was on at the close
   p_trig_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clus_trig |-> $past(cfg_sum_en));
   // R3: the readout pulse lasts exactly one cycle
   p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ro_valid |=> !ro_valid);
   // R4: no mask is shown outside a readout pulse
   p_mask_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ro_valid |-> (ro_mask == '0));
endmodule

// File: tb/cluster_sum_trigger_bench.sv
module cluster_sum_trigger_bench;
   localparam int NP = 127;
   localparam int CL = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [6:0]    hit_pix = '0;
   logic [1:0]    hit_code = '0;
   logic          nrg_valid = 1'b0;
   logic [6:0]    nrg_pix = '0;
   logic [7:0]    nrg_val = '0;
   logic          cfg_sum_en = 1'b0;
   logic [10:0]   cfg_sum_thr = '0;
   logic [7:0]    cfg_window = 8'd3;
   logic          tbl_we = 1'b0;
   logic [8:0]    tbl_addr = '0;
   logic [NP-1:0] tbl_data = '0;
   logic          ro_valid, clus_trig;
   logic [NP-1:0] ro_mask;

   int checks = 0, fails = 0, cycles = 0;
   string phase = "R1";
   bit done = 1'b0;

   always #5 clk = ~clk;

   cluster_sum_trigger u_cluster_sum_trigger (.*);

   // behavioural reference model
   logic [NP-1:0] mtbl [512];
   bit            m_open;
   int            m_cnt, m_sum;
   logic [NP-1:0] m_mask;
   bit            e_valid, e_trig;
   logic [NP-1:0] e_mask;

   function automatic logic [NP-1:0] nb(input int p);
      logic [NP-1:0] m = '0;
      int q = p % CL, r = p / CL;
      int cand [6][2] = '{'{q+1,r}, '{q-1,r}, '{q,r+1}, '{q,r-1}, '{q+1,r-1}, '{q-1,r+1}};
      m[p] = 1'b1;
      foreach (cand[k])
         if (cand[k][0] >= 0 && cand[k][0] < CL && cand[k][1] >= 0 && cand[k][1]*CL + cand[k][0] < NP)
            m[cand[k][1]*CL + cand[k][0]] = 1'b1;
      return m;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 512; i++) mtbl[i] = (i % 4 == 0 || i >= 4*NP) ? '0 : nb(i / 4);
         m_open = 0; m_cnt = 0; m_sum = 0; m_mask = '0;
         e_valid = 0; e_trig = 0; e_mask = '0;
      end else begin
         bit hv, st, ein;
         logic [NP-1:0] hm, mg;
         int ns;
         hv  = hit_code != 2'b00 && hit_pix < 7'(NP);
         hm  = hv ? mtbl[int'(hit_pix)*4 + int'(hit_code)] : '0;
         mg  = (m_open ? m_mask : '0) | hm;
         st  = !m_open && hv;
         ein = nrg_valid && nrg_pix < 7'(NP) && (m_open || hv) && mg[nrg_pix];
         ns  = (st ? 0 : m_sum) + (ein ? int'(nrg_val) : 0);
         if (ns > 2047) ns = 2047;
         e_valid = 0; e_trig = 0; e_mask = '0;
         if (st) begin
            m_open = 1; m_cnt = (cfg_window == 0) ? 1 : int'(cfg_window);
            m_mask = hm; m_sum = ns;
         end else if (m_open) begin
            m_sum = ns; m_mask = mg;
            if (m_cnt == 1) begin
               e_valid = 1; e_mask = mg; e_trig = cfg_sum_en && ns >= int'(cfg_sum_thr);
               m_open = 0;
            end else m_cnt--;
         end
         if (tbl_we && tbl_addr < 9'(4*NP)) mtbl[tbl_addr] = tbl_data;
      end
   end

   task automatic check(input string tag, input string what, input logic [NP-1:0] act, input logic [NP-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) if (rst_n && !done) begin
      check(phase, "ro_valid", NP'(ro_valid), NP'(e_valid));
      check(phase, "ro_mask", ro_mask, e_mask);
      check(phase, "clus_trig", NP'(clus_trig), NP'(e_trig));
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic drive(input int hp, input int hc, input int nv, input int np, input int ev);
      @(negedge clk);
      hit_pix = 7'(hp); hit_code = 2'(hc);
      nrg_valid = nv[0]; nrg_pix = 7'(np); nrg_val = 8'(ev);
   endtask

   task automatic idle(); drive(0, 0, 0, 0, 0); endtask

   // wait for the readout pulse; returns latency in negedges
   task automatic wait_close(output int lat, output logic [NP-1:0] m, output logic t);
      lat = 0; m = '0; t = 1'b0;
      for (int i = 0; i < 40; i++) begin
         idle(); lat++;
         if (ro_valid) begin m = ro_mask; t = clus_trig; return; end
      end
      lat = -1;
   endtask

   task automatic bits(output logic [NP-1:0] m, input int list [$]);
      m = '0;
      foreach (list[i]) m[list[i]] = 1'b1;
   endtask

   initial begin
      int lat; logic [NP-1:0] m, ex; logic t; int seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      check("R1", "ro_valid after reset", NP'(ro_valid), '0);
      check("R1", "clus_trig after reset", NP'(clus_trig), '0);
      check("R1", "ro_mask after reset", ro_mask, '0);

      // R1: default interior, corner and last-pixel masks
      cfg_window = 8'd3;
      drive(20, 1, 0, 0, 0); wait_close(lat, m, t);
      bits(ex, '{20, 21, 19, 36, 4, 5, 35}); check("R1", "interior default", m, ex);
      drive(0, 3, 0, 0, 0); wait_close(lat, m, t);
      bits(ex, '{0, 1, 16}); check("R1", "corner default", m, ex);
      drive(126, 2, 0, 0, 0); wait_close(lat, m, t);
      bits(ex, '{126, 125, 110, 111}); check("R1", "last pixel default", m, ex);

      // R2: code 00 and an out-of-range pixel open no window
      phase = "R2";
      seen = 0;
      drive(20, 0, 0, 0, 0);
      for (int i = 0; i < 6; i++) begin idle(); if (ro_valid) seen++; end
      check("R2", "no window on code 00", NP'(seen), '0);
      seen = 0;
      drive(127, 3, 0, 0, 0);
      for (int i = 0; i < 6; i++) begin idle(); if (ro_valid) seen++; end
      check("R2", "no window on pixel 127", NP'(seen), '0);

      // R3: close timing for windows of 1, 5 and 0
      phase = "R3";
      cfg_window = 8'd1; drive(40, 1, 0, 0, 0); wait_close(lat, m, t);
      check("R3", "latency W=1", NP'(lat), NP'(2));
      cfg_window = 8'd5; drive(40, 1, 0, 0, 0); wait_close(lat, m, t);
      check("R3", "latency W=5", NP'(lat), NP'(6));
      cfg_window = 8'd0; drive(40, 1, 0, 0, 0); wait_close(lat, m, t);
      check("R3", "latency W=0", NP'(lat), NP'(2));

      // R4: two hits merge, the second on the closing edge
      phase = "R4";
      cfg_window = 8'd3;
      drive(20, 1, 0, 0, 0); idle(); idle(); drive(0, 1, 0, 0, 0);
      wait_close(lat, m, t);
      bits(ex, '{20, 21, 19, 36, 4, 5, 35, 0, 1, 16}); check("R4", "merged mask", m, ex);

      // R5 and R9: rewrite the low-code entry of pixel 30
      phase = "R5";
      @(negedge clk); tbl_we = 1'b1; tbl_addr = 9'(30*4 + 1); tbl_data = '0; tbl_data[100] = 1'b1;
      drive(30, 1, 0, 0, 0); tbl_we = 1'b0; wait_close(lat, m, t);
      bits(ex, '{100}); check("R5", "written entry used", m, ex);
      phase = "R9";
      drive(30, 2, 0, 0, 0); wait_close(lat, m, t);
      check("R9", "mid code keeps default", m, nb(30));

      // R6 and R7: energy sum exactly at threshold, outside report ignored
      phase = "R6";
      cfg_sum_en = 1'b1; cfg_sum_thr = 11'd300; cfg_window = 8'd4;
      drive(20, 1, 1, 20, 100); drive(0, 0, 1, 21, 100); drive(0, 0, 1, 50, 200); drive(0, 0, 1, 36, 100);
      wait_close(lat, m, t);
      check("R6", "sum 300 meets threshold 300", NP'(t), NP'(1));
      phase = "R7";
      cfg_sum_thr = 11'd301;
      drive(20, 1, 1, 20, 100); drive(0, 0, 1, 21, 100); drive(0, 0, 1, 50, 200); drive(0, 0, 1, 36, 100);
      wait_close(lat, m, t);
      check("R7", "sum 300 below threshold 301", NP'(t), '0);
      cfg_sum_en = 1'b0; cfg_sum_thr = 11'd300;
      drive(20, 1, 1, 20, 100); drive(0, 0, 1, 21, 100); drive(0, 0, 1, 36, 100);
      wait_close(lat, m, t);
      check("R7", "sum mode off", NP'(t), '0);

      // R8: twelve full-scale reports saturate at 2047
      phase = "R8";
      cfg_sum_en = 1'b1; cfg_sum_thr = 11'd2047; cfg_window = 8'd20;
      drive(20, 1, 1, 20, 255);
      for (int i = 0; i < 11; i++) drive(0, 0, 1, 20, 255);
      wait_close(lat, m, t);
      check("R8", "saturated total meets 2047", NP'(t), NP'(1));

      repeat (3) idle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule